// File: doc/BRIEF.md
# AXI-Stream Packet Format Monitor

This block watches an AXI-Stream slave interface without taking part in it. It reads the handshake and packet-framing signals and checks each transferred beat against a byte-enable rule. Every beat except the last one of a packet must enable all bytes. The last beat must enable a run of bytes that starts at the lowest byte and has no holes. A beat with no bytes enabled is accepted only when it forms a whole packet by itself, and only if that case is enabled by a parameter. Each kind of violation sets its own sticky cause bit. A one-cycle pulse marks every violating beat.

The monitor also takes the sideband fields (user, destination and stream identifier) from the first transferred beat of each packet. It holds them until the next packet starts, and marks each capture with a one-cycle strobe. The block never drives the ready signal and has no data path. The data width sets only the number of keep bits.

Top module: `axis_fmt_monitor`

## Requirements
- R1: A beat counts only in a cycle where both `s_tvalid` and `s_tready` are high. A cycle without a transfer changes no flag, raises no pulse and captures no sideband.
- R2: A transferred beat with `s_tlast` low and a keep value that is neither all ones nor all zeros sets `err_flags[0]` (keep cause).
- R3: A transferred beat with `s_tlast` high and a non-zero keep value that has a cleared bit below a set bit sets `err_flags[1]` (gap cause). A keep value contiguous from bit 0, such as 8'h07 or 8'hFF, raises no error.
- R4: A transferred beat with keep all zeros sets `err_flags[2]` (zero cause). The exception is a beat that is both first and last of its packet while `ALLOW_NULL` is 1, which raises no error.
- R5: The first beat of a packet is the first transferred beat after reset, or the first transferred beat after a transferred beat with `s_tlast` high.
- R6: On a first beat, `sb_user`, `sb_dest` and `sb_id` take the beat's sideband values one cycle later. `sb_valid` is high for exactly that one cycle. Sideband values on later beats are ignored, and the captured values stay unchanged.
- R7: Cause bits stay set until `err_clr` is high at a clock edge, which clears them. If a violation occurs in the same cycle as the clear, the new cause bits remain set.
- R8: `err_pulse` is high for one cycle, in the cycle after each violating beat. This includes a beat whose cause bit was already set.
- R9: After reset, `err_flags` is 0, `err_pulse` is 0, `sb_valid` is 0 and the sideband outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tvalid | input | 1 | Observed valid |
| s_tready | input | 1 | Observed ready |
| s_tkeep | input | DATA_W/8 | Observed byte enables |
| s_tlast | input | 1 | Observed end of packet |
| s_tuser | input | USER_W | Observed user sideband |
| s_tdest | input | DEST_W | Observed destination sideband |
| s_tid | input | ID_W | Observed stream identifier |
| err_clr | input | 1 | Clears the sticky cause bits |
| err_flags | output | 3 | Sticky causes: bit0 keep, bit1 gap, bit2 zero |
| err_pulse | output | 1 | One-cycle pulse per violating beat |
| sb_user | output | USER_W | Captured user field |
| sb_dest | output | DEST_W | Captured destination field |
| sb_id | output | ID_W | Captured identifier field |
| sb_valid | output | 1 | One-cycle strobe on capture |

## Verification
The bench targets the cases a careless implementation gets wrong:
- **Null packet.** A single beat with no bytes enabled is legal, while an empty last beat after earlier beats is not. A design that ignores the first-beat condition either flags null packets or lets the empty tail through.
- **Gapped last beat.** A last-beat keep value with a hole must be flagged. A design that only counts set bits, or that treats the last beat like the others, reports the wrong cause.
- **Stalled handshake.** A bad keep value and fresh sideband values are offered while ready is low, and must change nothing. A design that ignores ready would latch or flag them.
- **Clear and violation together.** An error that coincides with a clear must survive, and a repeated violation must pulse again. This catches clear-priority mistakes and pulses derived from flag edges.

// File: rtl/axis_fmt_pkg.sv
// Package: shared cause-bit positions for the AXI-Stream format monitor.
// Assumes: consumers index err_flags with these constants.
package axis_fmt_pkg;
    localparam int CAUSE_W  = 3;
    localparam int C_KEEP   = 0;
    localparam int C_GAP    = 1;
    localparam int C_ZERO   = 2;
    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/axis_fmt_sof.sv
// Module: tracks which transferred beat opens a packet.
// Assumes: beat is the qualified handshake; reset puts the tracker at a packet start.
module axis_fmt_sof (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic last,
    output logic first
);
    logic first_q;

    // Purpose: next beat is a first beat exactly when the current beat closed a packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= 1'b1;
        else if (beat)
            first_q <= last;
    end

    assign first = first_q;

    p_sof_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> first);
    p_mid_after_body_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !last) |=> !first);
endmodule

// File: rtl/axis_fmt_keepchk.sv
// Module: classifies one beat's keep pattern into violation causes.
// Assumes: inputs only matter when a beat transfers; output is combinational.
module axis_fmt_keepchk
    import axis_fmt_pkg::*;
#(
    parameter int KEEP_W     = 8,
    parameter bit ALLOW_NULL = 1'b1
) (
    input  logic [KEEP_W-1:0] keep,
    input  logic              last,
    input  logic              first,
    output cause_t            cause
);
    logic is_zero, all_ones, contig, null_ok;
    logic [KEEP_W-1:0] keep_inc;

    // Purpose: derive pattern properties of the keep vector.
    always_comb begin
        keep_inc = keep + 1'b1;
        is_zero  = (keep == '0);
        all_ones = &keep;
        contig   = ((keep & keep_inc) == '0);
    end

    generate
        if (ALLOW_NULL) begin : g_null
            assign null_ok = first & last;
        end else begin : g_no_null
            assign null_ok = 1'b0;
        end
    endgenerate

    // Purpose: map pattern properties and position in packet onto cause bits.
    always_comb begin
        cause         = '0;
        cause[C_ZERO] = is_zero && !null_ok;
        cause[C_KEEP] = !last && !is_zero && !all_ones;
        cause[C_GAP]  = last && !is_zero && !contig;
    end

    // Purpose: each beat maps onto at most one cause.
    always_comb begin
        p_one_cause_r2: assert ($onehot0(cause));
    end
endmodule

// File: rtl/axis_fmt_errreg.sv
// Module: sticky cause register and per-violation pulse.
// Assumes: hit is only non-zero on a transferred beat; set wins over clear.
module axis_fmt_errreg
    import axis_fmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t hit,
    input  logic   clr,
    output cause_t flags,
    output logic   pulse
);
    cause_t flags_q;
    logic   pulse_q;

    // Purpose: accumulate causes, clearing on request with new hits kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            flags_q <= (clr ? '0 : flags_q) | hit;
            pulse_q <= |hit;
        end
    end

    assign flags = flags_q;
    assign pulse = pulse_q;

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));
    p_pulse_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (flags != '0));
endmodule

// File: rtl/axis_fmt_sbcap.sv
// Module: captures sideband fields from the first beat of each packet.
// Assumes: cap is high only on a transferred first beat.
module axis_fmt_sbcap #(
    parameter int USER_W = 8,
    parameter int DEST_W = 4,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [USER_W-1:0] user_i,
    input  logic [DEST_W-1:0] dest_i,
    input  logic [ID_W-1:0]   id_i,
    output logic [USER_W-1:0] user_o,
    output logic [DEST_W-1:0] dest_o,
    output logic [ID_W-1:0]   id_o,
    output logic              valid_o
);
    // Purpose: load fields on capture and strobe valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_o  <= '0;
            dest_o  <= '0;
            id_o    <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= cap;
            if (cap) begin
                user_o <= user_i;
                dest_o <= dest_i;
                id_o   <= id_i;
            end
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(user_o) && $stable(dest_o) && $stable(id_o) && !valid_o));
    p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> valid_o);
endmodule

// File: rtl/axis_fmt_monitor.sv
// Module: passive AXI-Stream format monitor (top).
// Assumes: observes the handshake only; never drives ready; DATA_W is a multiple of 8.
module axis_fmt_monitor
    import axis_fmt_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int USER_W     = 8,
    parameter int DEST_W     = 4,
    parameter int ID_W       = 4,
    parameter bit ALLOW_NULL = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s_tvalid,
    input  logic                  s_tready,
    input  logic [DATA_W/8-1:0]   s_tkeep,
    input  logic                  s_tlast,
    input  logic [USER_W-1:0]     s_tuser,
    input  logic [DEST_W-1:0]     s_tdest,
    input  logic [ID_W-1:0]       s_tid,
    input  logic                  err_clr,
    output logic [CAUSE_W-1:0]    err_flags,
    output logic                  err_pulse,
    output logic [USER_W-1:0]     sb_user,
    output logic [DEST_W-1:0]     sb_dest,
    output logic [ID_W-1:0]       sb_id,
    output logic                  sb_valid
);
    localparam int KEEP_W = DATA_W / 8;

    logic   beat, first;
    cause_t cause, hit;

    assign beat = s_tvalid & s_tready;
    assign hit  = beat ? cause : '0;

    axis_fmt_sof u_sof (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat),
        .last  (s_tlast),
        .first (first)
    );

    axis_fmt_keepchk #(.KEEP_W(KEEP_W), .ALLOW_NULL(ALLOW_NULL)) u_keep (
        .keep  (s_tkeep),
        .last  (s_tlast),
        .first (first),
        .cause (cause)
    );

    axis_fmt_errreg u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (err_clr),
        .flags (err_flags),
        .pulse (err_pulse)
    );

    axis_fmt_sbcap #(.USER_W(USER_W), .DEST_W(DEST_W), .ID_W(ID_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (beat & first),
        .user_i  (s_tuser),
        .dest_i  (s_tdest),
        .id_i    (s_tid),
        .user_o  (sb_user),
        .dest_o  (sb_dest),
        .id_o    (sb_id),
        .valid_o (sb_valid)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> (!err_pulse && !sb_valid));
endmodule

// File: tb/tb_axis_fmt_monitor.sv
module tb_axis_fmt_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_tvalid = 1'b0, s_tready = 1'b0, s_tlast = 1'b0, err_clr = 1'b0;
    logic [KW-1:0] s_tkeep = '0;
    logic [7:0]    s_tuser = '0;
    logic [3:0]    s_tdest = '0, s_tid = '0;
    logic [2:0]    err_flags;
    logic          err_pulse, sb_valid;
    logic [7:0]    sb_user;
    logic [3:0]    sb_dest, sb_id;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axis_fmt_monitor dut (
        .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tuser(s_tuser), .s_tdest(s_tdest),
        .s_tid(s_tid), .err_clr(err_clr), .err_flags(err_flags), .err_pulse(err_pulse),
        .sb_user(sb_user), .sb_dest(sb_dest), .sb_id(sb_id), .sb_valid(sb_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle at a negedge; return at the following negedge with outputs settled.
    task automatic cyc(input logic v, input logic r, input logic [KW-1:0] k, input logic l,
                       input logic [7:0] u, input logic [3:0] d, input logic [3:0] i,
                       input logic c);
        @(negedge clk);
        s_tvalid = v; s_tready = r; s_tkeep = k; s_tlast = l;
        s_tuser = u; s_tdest = d; s_tid = i; err_clr = c;
        @(negedge clk);
        s_tvalid = 1'b0; s_tready = 1'b1; err_clr = 1'b0;
    endtask

    task automatic beat(input logic [KW-1:0] k, input logic l, input logic [7:0] u);
        cyc(1'b1, 1'b1, k, l, u, u[3:0], u[7:4], 1'b0);
    endtask

    task automatic clear_flags();
        cyc(1'b0, 1'b1, '0, 1'b0, '0, '0, '0, 1'b1);
    endtask

    task automatic t_reset();
        chk("R9 flags", err_flags, 0);
        chk("R9 pulse", err_pulse, 0);
        chk("R9 sb_valid", sb_valid, 0);
        chk("R9 sb_user", sb_user, 0);
    endtask

    task automatic t_good_packet();
        beat(8'hFF, 1'b0, 8'hA5);
        chk("R6 capture valid", sb_valid, 1);
        chk("R6 user", sb_user, 8'hA5);
        chk("R6 dest", sb_dest, 4'h5);
        chk("R6 id", sb_id, 4'hA);
        beat(8'hFF, 1'b0, 8'h3C);
        chk("R6 no restrobe", sb_valid, 0);
        chk("R6 user held", sb_user, 8'hA5);
        beat(8'h07, 1'b1, 8'h77);
        chk("R3 contiguous last ok", err_flags, 0);
        chk("R6 user held on last", sb_user, 8'hA5);
        beat(8'hFF, 1'b1, 8'h12);
        chk("R5 new packet capture", sb_valid, 1);
        chk("R5 new user", sb_user, 8'h12);
        chk("R3 full last ok", err_flags, 0);
    endtask

    task automatic t_keep_err();
        beat(8'hF0, 1'b0, 8'h01);
        chk("R2 keep cause", err_flags, 3'b001);
        chk("R8 pulse", err_pulse, 1);
        beat(8'hFF, 1'b1, 8'h02);
        chk("R8 pulse one cycle", err_pulse, 0);
        chk("R7 sticky", err_flags, 3'b001);
        clear_flags();
        chk("R7 cleared", err_flags, 0);
    endtask

    task automatic t_gap();
        beat(8'h05, 1'b1, 8'h03);
        chk("R3 gap cause", err_flags, 3'b010);
        beat(8'h05, 1'b1, 8'h04);
        chk("R8 repeat pulse", err_pulse, 1);
        clear_flags();
    endtask

    task automatic t_zero();
        beat(8'h00, 1'b0, 8'h05);
        chk("R4 zero mid", err_flags, 3'b100);
        beat(8'h00, 1'b1, 8'h06);
        chk("R4 zero tail multi-beat", err_pulse, 1);
        clear_flags();
        beat(8'h00, 1'b1, 8'h07);
        chk("R4 null packet ok", err_flags, 0);
        chk("R4 null packet no pulse", err_pulse, 0);
        chk("R5 null packet captured", sb_user, 8'h07);
    endtask

    task automatic t_no_ready();
        cyc(1'b1, 1'b0, 8'h0F, 1'b0, 8'hEE, 4'hE, 4'hE, 1'b0);
        chk("R1 stalled no flag", err_flags, 0);
        chk("R1 stalled no pulse", err_pulse, 0);
        chk("R1 stalled no capture", sb_valid, 0);
        chk("R1 stalled user kept", sb_user, 8'h07);
        beat(8'hFF, 1'b1, 8'h44);
        chk("R1 next real beat is first", sb_user, 8'h44);
    endtask

    task automatic t_set_wins();
        beat(8'h0F, 1'b0, 8'h50);
        cyc(1'b1, 1'b1, 8'h09, 1'b1, 8'h51, 4'h1, 4'h5, 1'b1);
        chk("R7 set wins over clear", err_flags, 3'b010);
        clear_flags();
        chk("R7 clear after", err_flags, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                s_tready = 1'b1;
                t_good_packet();
                t_keep_err();
                t_gap();
                t_zero();
                t_no_ready();
                t_set_wins();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule